// File: doc/BRIEF.md
# Four-bit calculator datapath

This block is the arithmetic core of a small calculator. It holds two 4-bit working registers, A and B. An external sequencer steers it with a few control lines. Each cycle, an operand selector picks one of eight values to feed the ALU's first operand X:

- the external data word or its bitwise complement;
- register B or its complement;
- register A unshifted;
- register A shifted right arithmetically, shifted right logically, or shifted left logically.

The ALU combines X with register B and a carry-in using one of eight operations. The 4-bit result is offered to both registers, and either one captures it on a clock edge when its load line is high. The selector, shifters and ALU are purely combinational.

A sequencer builds micro-operations from this. It can load a register from the data word, accumulate sums, subtract, and shift A in place. It does this by choosing a select code and an opcode, then pulsing a load enable. The result, the carry-out and both register values are visible at the ports at all times.

Top module: `calc_datapath`

## Requirements
- R1: On a rising edge with reset low, a register whose load enable is 0 keeps its value, and one whose load enable is 1 takes the ALU result.
- R2: Reset (active high, synchronous) clears both registers to 0000 on the next rising edge, even when a load enable is 1 in the same cycle.
- R3: Select codes route X as follows: 000 register A, 100 register B, 101 inverted B, 110 data input, 111 inverted data input.
- R4: Select code 010 routes A shifted right by one with its MSB kept (1000 gives 1100, 0110 gives 0011).
- R5: Select code 011 routes A shifted right by one with a 0 entering the MSB (1010 gives 0101).
- R6: Select code 001 routes A shifted left by one with a 0 entering the LSB (0011 gives 0110, 1001 gives 0010).
- R7: Opcode 001 gives X+B+cin truncated to 4 bits, with the fifth bit on the carry-out (1010+0011 gives 1101 with cin 0 and 1110 with cin 1; 1111+0001 gives 0000 with carry 1).
- R8: Opcode 010 gives X+cin, with the carry-out set when the 4-bit value wraps.
- R9: Opcode 011 gives X−B−1+cin, computed as X plus the complement of B plus cin, with the carry-out set when that 5-bit sum overflows.
- R10: The remaining opcodes set the carry-out to 0 and give: 000 X unchanged (cin ignored), 100 X AND B, 101 X OR B, 110 X XOR B, and 111 NOT X.
- R11: The ALU result is the data input of both registers, so loading both in one cycle stores the same value in each.
- R12: The result and carry-out follow the select code, opcode, carry-in and data input within the same cycle. No clock edge is needed, and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of both registers |
| din | input | 4 | External data word |
| sel | input | 3 | Operand source code for X |
| alu_op | input | 3 | ALU operation code |
| cin | input | 1 | ALU carry-in |
| load_a | input | 1 | Load enable of register A |
| load_b | input | 1 | Load enable of register B |
| alu_out | output | 4 | ALU result |
| cout | output | 1 | ALU carry-out |
| reg_a | output | 4 | Current value of register A |
| reg_b | output | 4 | Current value of register B |

## Verification
The result and carry-out are combinational, so they are due in the same cycle as the change on `sel`, `alu_op`, `cin` or `din`. The bench drives those inputs on a falling edge and samples one nanosecond later, before any rising edge can intervene.

The register values pass through one flip-flop. A load or reset set up before a rising edge shows on `reg_a` and `reg_b` after that edge, and the bench reads them at the following falling edge. Every table vector first loads A and B through the data path and only then applies the operand and opcode under test.

// File: rtl/calc_pkg.sv
package calc_pkg;

  // Operand source codes for the ALU X input
  typedef enum logic [2:0] {
    SRC_A    = 3'b000,
    SRC_SHL  = 3'b001,
    SRC_SAR  = 3'b010,
    SRC_SHR  = 3'b011,
    SRC_B    = 3'b100,
    SRC_NB   = 3'b101,
    SRC_DIN  = 3'b110,
    SRC_NDIN = 3'b111
  } src_e;

  // ALU operation codes
  typedef enum logic [2:0] {
    OP_PASS = 3'b000,
    OP_ADD  = 3'b001,
    OP_INC  = 3'b010,
    OP_SUB  = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_NOT  = 3'b111
  } op_e;

  // Shift flavours applied to register A
  typedef enum int {
    SH_SAR = 0,
    SH_SHR = 1,
    SH_SHL = 2
  } shift_e;

  localparam int NUM_SHIFTS = 3;

endpackage

// File: rtl/calc_shift.sv
module calc_shift #(
  parameter int              W    = 4,
  parameter calc_pkg::shift_e KIND = calc_pkg::SH_SAR
) (
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (KIND == calc_pkg::SH_SAR) begin : g_sar
      // right by one, sign bit replicated
      assign q = {d[W-1], d[W-1:1]};
    end else if (KIND == calc_pkg::SH_SHR) begin : g_shr
      // right by one, zero enters at the top
      assign q = {1'b0, d[W-1:1]};
    end else begin : g_shl
      // left by one, zero enters at the bottom
      assign q = {d[W-2:0], 1'b0};
    end
  endgenerate

endmodule

// File: rtl/calc_opsel.sv
module calc_opsel #(
  parameter int W     = 4,
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [W-1:0]     din,
  input  logic [W-1:0]     a_sar,
  input  logic [W-1:0]     a_shr,
  input  logic [W-1:0]     a_shl,
  output logic [W-1:0]     x
);
  import calc_pkg::*;

  always_comb begin
    case (src_e'(sel))
      SRC_A:    x = a;
      SRC_SHL:  x = a_shl;
      SRC_SAR:  x = a_sar;
      SRC_SHR:  x = a_shr;
      SRC_B:    x = b;
      SRC_NB:   x = ~b;
      SRC_DIN:  x = din;
      SRC_NDIN: x = ~din;
      default:  x = '0;
    endcase
  end

endmodule

// File: rtl/calc_alu.sv
module calc_alu #(
  parameter int W    = 4,
  parameter int OP_W = 3
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    x,
  input  logic [W-1:0]    y,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            cout
);
  import calc_pkg::*;

  localparam int WS = W + 1;

  logic [WS-1:0] x_ext;
  logic [WS-1:0] y_ext;
  logic [WS-1:0] ny_ext;
  logic [WS-1:0] c_ext;
  logic [WS-1:0] acc;

  assign x_ext  = {1'b0, x};
  assign y_ext  = {1'b0, y};
  assign ny_ext = {1'b0, ~y};
  assign c_ext  = {{W{1'b0}}, cin};

  always_comb begin
    case (op_e'(op))
      OP_PASS: acc = x_ext;
      OP_ADD:  acc = x_ext + y_ext + c_ext;
      OP_INC:  acc = x_ext + c_ext;
      OP_SUB:  acc = x_ext + ny_ext + c_ext;
      OP_AND:  acc = {1'b0, x & y};
      OP_OR:   acc = {1'b0, x | y};
      OP_XOR:  acc = {1'b0, x ^ y};
      OP_NOT:  acc = {1'b0, ~x};
      default: acc = '0;
    endcase
  end

  assign res  = acc[W-1:0];
  assign cout = acc[W];

endmodule

// File: rtl/calc_reg.sv
module calc_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/calc_datapath.sv
module calc_datapath #(
  parameter int W     = 4,
  parameter int SEL_W = 3,
  parameter int OP_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     din,
  input  logic [SEL_W-1:0] sel,
  input  logic [OP_W-1:0]  alu_op,
  input  logic             cin,
  input  logic             load_a,
  input  logic             load_b,
  output logic [W-1:0]     alu_out,
  output logic             cout,
  output logic [W-1:0]     reg_a,
  output logic [W-1:0]     reg_b
);
  import calc_pkg::*;

  localparam int NREG = 2;

  logic [W-1:0] shv [NUM_SHIFTS];
  logic [W-1:0] x_op;
  logic [W-1:0] res;
  logic [W-1:0] regq [NREG];
  logic [NREG-1:0] ld;

  assign ld = {load_b, load_a};

  // one register file entry per working register, both fed by the ALU
  generate
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      calc_reg #(.W(W)) u_reg (
        .clk (clk),
        .rst (rst),
        .en  (ld[r]),
        .d   (res),
        .q   (regq[r])
      );
    end
  endgenerate

  assign reg_a = regq[0];
  assign reg_b = regq[1];

  // the three shift flavours of register A
  generate
    for (genvar k = 0; k < NUM_SHIFTS; k++) begin : g_shift
      calc_shift #(.W(W), .KIND(shift_e'(k))) u_shift (
        .d (regq[0]),
        .q (shv[k])
      );
    end
  endgenerate

  calc_opsel #(.W(W), .SEL_W(SEL_W)) u_opsel (
    .sel   (sel),
    .a     (regq[0]),
    .b     (regq[1]),
    .din   (din),
    .a_sar (shv[SH_SAR]),
    .a_shr (shv[SH_SHR]),
    .a_shl (shv[SH_SHL]),
    .x     (x_op)
  );

  calc_alu #(.W(W), .OP_W(OP_W)) u_alu (
    .op   (alu_op),
    .x    (x_op),
    .y    (regq[1]),
    .cin  (cin),
    .res  (res),
    .cout (cout)
  );

  assign alu_out = res;

endmodule

// File: rtl/calc_datapath_checker.sv
module calc_datapath_checker #(
  parameter int W     = 4,
  parameter int SEL_W = 3,
  parameter int OP_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     din,
  input logic [SEL_W-1:0] sel,
  input logic [OP_W-1:0]  alu_op,
  input logic             cin,
  input logic             load_a,
  input logic             load_b,
  input logic [W-1:0]     alu_out,
  input logic             cout,
  input logic [W-1:0]     reg_a,
  input logic [W-1:0]     reg_b
);

  assert_hold_a_R1: assert property (@(posedge clk) disable iff (rst)
    !load_a |=> reg_a == $past(reg_a));

  assert_hold_b_R1: assert property (@(posedge clk) disable iff (rst)
    !load_b |=> reg_b == $past(reg_b));

  assert_clear_R2: assert property (@(posedge clk)
    rst |=> (reg_a == '0 && reg_b == '0));

  assert_not_b_R3: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'b101 && alu_op == 3'b000) |-> alu_out == ~reg_b);

  assert_sar_R4: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'b010 && alu_op == 3'b000) |-> alu_out == {reg_a[W-1], reg_a[W-1:1]});

  assert_add_b_R7: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'b100 && alu_op == 3'b001) |->
      {cout, alu_out} == ({1'b0, reg_b} + {1'b0, reg_b} + {{W{1'b0}}, cin}));

  assert_no_carry_R10: assert property (@(posedge clk) disable iff (rst)
    (alu_op[2] || alu_op == 3'b000) |-> !cout);

  assert_not_din_R10: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'b110 && alu_op == 3'b111) |-> alu_out == ~din);

  assert_load_a_R11: assert property (@(posedge clk) disable iff (rst)
    load_a |=> reg_a == $past(alu_out));

  assert_load_b_R11: assert property (@(posedge clk) disable iff (rst)
    load_b |=> reg_b == $past(alu_out));

endmodule

bind calc_datapath calc_datapath_checker #(.W(W), .SEL_W(SEL_W), .OP_W(OP_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .din     (din),
  .sel     (sel),
  .alu_op  (alu_op),
  .cin     (cin),
  .load_a  (load_a),
  .load_b  (load_b),
  .alu_out (alu_out),
  .cout    (cout),
  .reg_a   (reg_a),
  .reg_b   (reg_b)
);

// File: tb/calc_datapath_test.sv
module calc_datapath_test;

  localparam int W    = 4;
  localparam int NV   = 23;
  localparam int WDOG = 200000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic [2:0]   sel = '0;
  logic [2:0]   alu_op = '0;
  logic         cin = 1'b0;
  logic         load_a = 1'b0;
  logic         load_b = 1'b0;
  logic [W-1:0] alu_out;
  logic         cout;
  logic [W-1:0] reg_a;
  logic [W-1:0] reg_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  calc_datapath #(.W(W)) uut (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .sel     (sel),
    .alu_op  (alu_op),
    .cin     (cin),
    .load_a  (load_a),
    .load_b  (load_b),
    .alu_out (alu_out),
    .cout    (cout),
    .reg_a   (reg_a),
    .reg_b   (reg_b)
  );

  // fields: a, b, din, sel, op, cin, expected cout, expected result
  localparam logic [23:0] VEC [NV] = '{
    {4'b0110, 4'b0000, 4'b0000, 3'b000, 3'b000, 1'b0, 1'b0, 4'b0110}, // R3 A
    {4'b0000, 4'b1101, 4'b0000, 3'b100, 3'b000, 1'b0, 1'b0, 4'b1101}, // R3 B
    {4'b0000, 4'b1101, 4'b0000, 3'b101, 3'b000, 1'b0, 1'b0, 4'b0010}, // R3 ~B
    {4'b0000, 4'b0000, 4'b1001, 3'b110, 3'b000, 1'b0, 1'b0, 4'b1001}, // R3 din
    {4'b0000, 4'b0000, 4'b1001, 3'b111, 3'b000, 1'b0, 1'b0, 4'b0110}, // R3 ~din
    {4'b1000, 4'b0000, 4'b0000, 3'b010, 3'b000, 1'b0, 1'b0, 4'b1100}, // R4
    {4'b0110, 4'b0000, 4'b0000, 3'b010, 3'b000, 1'b0, 1'b0, 4'b0011}, // R4
    {4'b1010, 4'b0000, 4'b0000, 3'b011, 3'b000, 1'b0, 1'b0, 4'b0101}, // R5
    {4'b0011, 4'b0000, 4'b0000, 3'b001, 3'b000, 1'b0, 1'b0, 4'b0110}, // R6
    {4'b1001, 4'b0000, 4'b0000, 3'b001, 3'b000, 1'b0, 1'b0, 4'b0010}, // R6
    {4'b0000, 4'b0011, 4'b1010, 3'b110, 3'b001, 1'b0, 1'b0, 4'b1101}, // R7
    {4'b0000, 4'b0011, 4'b1010, 3'b110, 3'b001, 1'b1, 1'b0, 4'b1110}, // R7
    {4'b0000, 4'b0001, 4'b1111, 3'b110, 3'b001, 1'b0, 1'b1, 4'b0000}, // R7
    {4'b1111, 4'b0000, 4'b0000, 3'b000, 3'b010, 1'b1, 1'b1, 4'b0000}, // R8
    {4'b0101, 4'b0000, 4'b0000, 3'b000, 3'b010, 1'b0, 1'b0, 4'b0101}, // R8
    {4'b0000, 4'b0010, 4'b0111, 3'b110, 3'b011, 1'b1, 1'b1, 4'b0101}, // R9
    {4'b0000, 4'b0101, 4'b0010, 3'b110, 3'b011, 1'b1, 1'b0, 4'b1101}, // R9
    {4'b0000, 4'b0011, 4'b0101, 3'b110, 3'b011, 1'b0, 1'b1, 4'b0001}, // R9
    {4'b0000, 4'b1010, 4'b1100, 3'b110, 3'b100, 1'b0, 1'b0, 4'b1000}, // R10
    {4'b0000, 4'b1010, 4'b1100, 3'b110, 3'b101, 1'b1, 1'b0, 4'b1110}, // R10
    {4'b0000, 4'b1010, 4'b1100, 3'b110, 3'b110, 1'b0, 1'b0, 4'b0110}, // R10
    {4'b0000, 4'b1010, 4'b1100, 3'b110, 3'b111, 1'b1, 1'b0, 4'b0011}, // R10
    {4'b0000, 4'b1010, 4'b1100, 3'b110, 3'b000, 1'b1, 1'b0, 4'b1100}  // R10
  };

  function automatic string tag_of(logic [2:0] s, logic [2:0] o);
    case (o)
      3'b001:  return "R7";
      3'b010:  return "R8";
      3'b011:  return "R9";
      3'b000: begin
        case (s)
          3'b010:  return "R4";
          3'b011:  return "R5";
          3'b001:  return "R6";
          default: return "R3";
        endcase
      end
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // load A then B through the data input pass path
  task automatic load_ab(logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    rst = 1'b0; sel = 3'b110; alu_op = 3'b000; cin = 1'b0;
    din = a; load_a = 1'b1; load_b = 1'b0;
    @(negedge clk);
    din = b; load_a = 1'b0; load_b = 1'b1;
    @(negedge clk);
    load_b = 1'b0;
  endtask

  initial begin
    #(4 * WDOG);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state (R2)
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R2", "reset reg_a", {4'b0, reg_a}, 8'h00);
    check("R2", "reset reg_b", {4'b0, reg_b}, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      load_ab(VEC[i][23:20], VEC[i][19:16]);
      check("R11", "preload reg_a", {4'b0, reg_a}, {4'b0, VEC[i][23:20]});
      check("R11", "preload reg_b", {4'b0, reg_b}, {4'b0, VEC[i][19:16]});
      din = VEC[i][15:12]; sel = VEC[i][11:9]; alu_op = VEC[i][8:6]; cin = VEC[i][5];
      #1;
      check(tag_of(VEC[i][11:9], VEC[i][8:6]), $sformatf("vector %0d", i),
            {3'b0, cout, alu_out}, {3'b0, VEC[i][4], VEC[i][3:0]});
    end

    // R1: hold with both enables low while result differs
    load_ab(4'b0101, 4'b0011);
    @(negedge clk);
    sel = 3'b110; alu_op = 3'b000; din = 4'b1111; load_a = 1'b0; load_b = 1'b0;
    @(negedge clk);
    check("R1", "hold reg_a", {4'b0, reg_a}, 8'h05);
    check("R1", "hold reg_b", {4'b0, reg_b}, 8'h03);

    // R11: A <- A + 1, captured from the ALU
    sel = 3'b000; alu_op = 3'b010; cin = 1'b1; load_a = 1'b1;
    @(negedge clk);
    load_a = 1'b0; cin = 1'b0;
    check("R11", "A incremented", {4'b0, reg_a}, 8'h06);
    check("R1", "B untouched", {4'b0, reg_b}, 8'h03);

    // R11: both registers load the same result (A + B = 6 + 3 = 9)
    sel = 3'b000; alu_op = 3'b001; cin = 1'b0; load_a = 1'b1; load_b = 1'b1;
    @(negedge clk);
    load_a = 1'b0; load_b = 1'b0;
    check("R11", "dual load reg_a", {4'b0, reg_a}, 8'h09);
    check("R11", "dual load reg_b", {4'b0, reg_b}, 8'h09);

    // R6 in place: A <- shl(A), 1001 -> 0010
    sel = 3'b001; alu_op = 3'b000; load_a = 1'b1;
    @(negedge clk);
    load_a = 1'b0;
    check("R6", "shift in place", {4'b0, reg_a}, 8'h02);

    // R12: result follows inputs mid-cycle, registers unchanged
    sel = 3'b110; alu_op = 3'b000; din = 4'b1010;
    #1;
    check("R12", "result tracks din", {3'b0, cout, alu_out}, 8'h0A);
    din = 4'b0001;
    #1;
    check("R12", "result tracks din again", {3'b0, cout, alu_out}, 8'h01);
    check("R12", "reg_a unchanged", {4'b0, reg_a}, 8'h02);

    // R2: reset wins over load
    @(negedge clk);
    din = 4'b1111; load_a = 1'b1; load_b = 1'b1; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; load_a = 1'b0; load_b = 1'b0;
    check("R2", "reset over load reg_a", {4'b0, reg_a}, 8'h00);
    check("R2", "reset over load reg_b", {4'b0, reg_b}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule